// File: doc/BRIEF.md
# Edge-Enabled Interrupt Latch Bank

This block watches a small group of asynchronous status levels: bus-voltage valid, session valid, session end and ID-grounded. It raises an interrupt when one of them changes in a direction that software has chosen. Each source has two enable bits, one for a 0-to-1 change and one for a 1-to-0 change. A change that is enabled sets a sticky latch bit for that source. The same change also fires a one-cycle report strobe, which tells the command sender to report the new line status to the link.

Software reaches the block through a simple synchronous register port. Both enable registers can be written whole, or have bits set or cleared, through three neighbouring addresses. A read-only status address returns the synchronised source levels. The latch register is read at its base address and is emptied only through its clear alias. The interrupt output is high while any latch bit is set.

Source bit order (bit 0 upward): vbus-valid, session-valid, session-end, ID-ground.

Top module: `edge_irq_bank`

## Requirements
- R1: After reset, both enable registers read 07h (bits 0 to 2 set, bit 3 clear), the latch register reads 00h and `irq` is low.
- R2: The rising-edge enable register lives at 0Dh, 0Eh and 0Fh, and any of the three addresses reads it. A write to 0Dh replaces it, a write to 0Eh ORs the data into it, and a write to 0Fh clears every bit that is 1 in the data.
- R3: The falling-edge enable register follows the same scheme at 10h (replace), 11h (set) and 12h (clear).
- R4: Address 13h returns the current source levels after a two-flop synchroniser, in bits 0 to 3. Writes to 13h change nothing.
- R5: A 0-to-1 change on a source whose rising enable bit is 1 sets that source's latch bit. The latch bit and `rpt_stb` become visible three clock edges after the input changes. A change whose enable bit is 0 has no effect.
- R6: A 1-to-0 change on a source whose falling enable bit is 1 sets that source's latch bit, with the same three-edge latency.
- R7: The latch register reads at 14h. A write to 16h clears every latch bit that is 1 in the data. Writes to 14h and 15h leave the latch unchanged.
- R8: When a clear write and a new event for the same bit fall in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while at least one latch bit is set.
- R10: `rpt_stb` is high for one cycle for each cycle in which at least one enabled event occurs. Several sources changing together give a single pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 4 | Asynchronous source levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Active-high interrupt |
| rpt_stb | output | 1 | One-cycle request to send a status report |

## Verification
Four things are checked by assertions on every cycle. A latch bit may rise only together with a report strobe. It may fall only after a write to the clear alias. A strobe always comes with a raised interrupt and needs an enable bit. A set-alias write leaves every written bit on. Other behaviour can only be shown by the bench's scenarios: the exact three-edge latency, that a disabled direction is ignored, that two sources changing together give one strobe, and that a new event beats a clear in the same cycle.

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
  parameter int NSRC = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [DW-1:0] EN_DEFAULT = 8'h07,
  parameter logic [AW-1:0] RISE_BASE = 8'h0D,
  parameter logic [AW-1:0] FALL_BASE = 8'h10,
  parameter logic [AW-1:0] STAT_ADDR = 8'h13,
  parameter logic [AW-1:0] LAT_BASE = 8'h14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          rpt_stb
);

  localparam logic [DW-1:0] SRC_MASK = {{(DW-NSRC){1'b0}}, {NSRC{1'b1}}};
  localparam logic [AW-1:0] RISE_SET = RISE_BASE + 1'b1;
  localparam logic [AW-1:0] RISE_CLR = RISE_BASE + 2'd2;
  localparam logic [AW-1:0] FALL_SET = FALL_BASE + 1'b1;
  localparam logic [AW-1:0] FALL_CLR = FALL_BASE + 2'd2;
  localparam logic [AW-1:0] LAT_CLR  = LAT_BASE + 2'd2;

  logic [NSRC-1:0] sync1, sync2, prev;
  logic [DW-1:0] rise_en, fall_en, latch_q;
  logic [DW-1:0] lvl, old, wd, ev, clr_mask;

  assign lvl = {{(DW-NSRC){1'b0}}, sync2};
  assign old = {{(DW-NSRC){1'b0}}, prev};
  assign wd  = reg_wdata & SRC_MASK;
  assign ev  = (lvl & ~old & rise_en) | (~lvl & old & fall_en);
  assign clr_mask = (reg_we && reg_addr == LAT_CLR) ? wd : '0;
  assign irq = |latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= EN_DEFAULT & SRC_MASK;
      fall_en <= EN_DEFAULT & SRC_MASK;
    end else if (reg_we) begin
      case (reg_addr)
        RISE_BASE: rise_en <= wd;
        RISE_SET:  rise_en <= rise_en | wd;
        RISE_CLR:  rise_en <= rise_en & ~wd;
        FALL_BASE: fall_en <= wd;
        FALL_SET:  fall_en <= fall_en | wd;
        FALL_CLR:  fall_en <= fall_en & ~wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      rpt_stb <= 1'b0;
    end else begin
      latch_q <= (latch_q & ~clr_mask) | ev;
      rpt_stb <= |ev;
    end
  end

  always_comb begin
    case (reg_addr)
      RISE_BASE, RISE_SET, RISE_CLR: reg_rdata = rise_en;
      FALL_BASE, FALL_SET, FALL_CLR: reg_rdata = fall_en;
      STAT_ADDR:                     reg_rdata = lvl;
      LAT_BASE, LAT_BASE + 1'b1, LAT_CLR: reg_rdata = latch_q;
      default:                       reg_rdata = '0;
    endcase
  end

  // R5 R6
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(latch_q & ~$past(latch_q))) |-> rpt_stb);

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(latch_q) & ~latch_q)) |-> $past(reg_we && reg_addr == LAT_CLR));

  // R9 R10
  stb_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_stb |-> irq);

  // R10
  stb_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_stb |-> |($past(rise_en) | $past(fall_en)));

  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RISE_SET) |=>
      ((rise_en & $past(wd)) == $past(wd)));

endmodule

// File: tb/edge_irq_bank_test.sv
module edge_irq_bank_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] src_in = '0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 8'h14, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, rpt_stb;

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  edge_irq_bank uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rpt_stb(rpt_stb));

  always #5 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic push(logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic cmp(logic [7:0] act, logic [7:0] e, string tag);
    vectors++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, act, e);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    reg_addr = a; #2; cmp(reg_rdata, e, tag); reg_addr = 8'h14;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick();
    reg_we = 0; reg_addr = 8'h14;
  endtask

  always @(negedge clk) begin
    if (rst_n && rpt_stb) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R10: unexpected strobe, latch %02h expected none", reg_rdata);
      end else begin
        string t;
        t = tag_q.pop_front();
        cmp(reg_rdata, exp_q.pop_front(), t);
      end
    end
  end

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1; tick();
    // R1
    rd(8'h0D, 8'h07, "R1 rise"); rd(8'h10, 8'h07, "R1 fall");
    rd(8'h14, 8'h00, "R1 latch"); cmp({7'd0, irq}, 0, "R1 irq");
    // R2
    wr(8'h0D, 8'h09); rd(8'h0D, 8'h09, "R2 write");
    wr(8'h0E, 8'h02); rd(8'h0E, 8'h0B, "R2 set");
    wr(8'h0F, 8'h08); rd(8'h0F, 8'h03, "R2 clear");
    // R3
    wr(8'h10, 8'h0C); rd(8'h10, 8'h0C, "R3 write");
    wr(8'h11, 8'h01); rd(8'h11, 8'h0D, "R3 set");
    wr(8'h12, 8'h04); rd(8'h12, 8'h09, "R3 clear");
    // R4 R5: bit0 rise enabled, bit2 rise disabled
    push(8'h01, "R5 rise bit0");
    src_in = 4'b0101; tick(2);
    rd(8'h13, 8'h05, "R4 status");
    wr(8'h13, 8'hFF); tick(4);
    rd(8'h13, 8'h05, "R4 write ignored");
    rd(8'h14, 8'h01, "R5 latch"); cmp({7'd0, irq}, 1, "R9 irq set");
    // R7
    wr(8'h14, 8'hFF); wr(8'h15, 8'hFF); rd(8'h14, 8'h01, "R7 writes ignored");
    wr(8'h16, 8'h01); rd(8'h14, 8'h00, "R7 clear"); cmp({7'd0, irq}, 0, "R9 irq low");
    // R6: bit0 fall enabled, bit2 fall disabled
    push(8'h01, "R6 fall bit0");
    src_in = 4'b0000; tick(6);
    rd(8'h14, 8'h01, "R6 latch"); wr(8'h16, 8'h0F);
    // R10: two sources together, one strobe
    push(8'h03, "R10 joint event");
    src_in = 4'b0011; tick(6);
    rd(8'h14, 8'h03, "R10 latch"); wr(8'h16, 8'h03);
    cmp(exp_q.size(), 0, "R10 strobe count");
    // R5 disabled rise on bit3, then enabled fall
    src_in = 4'b1011; tick(6);
    rd(8'h14, 8'h00, "R5 disabled edge");
    push(8'h08, "R6 fall bit3");
    src_in = 4'b0011; tick(6);
    // R8: fall on bit1 colliding with clear of bits 1 and 3
    wr(8'h11, 8'h02);
    push(8'h02, "R8 event beats clear");
    src_in = 4'b0001; tick(2);
    wr(8'h16, 8'h0A); tick(4);
    rd(8'h14, 8'h02, "R8 latch"); cmp({7'd0, irq}, 1, "R9 irq after collision");
    cmp(exp_q.size(), 0, "R10 all strobes seen");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule